// File: doc/BRIEF.md
# Atomic Fetch-and-Add Unit

This unit serves one atomic fetch-and-add request at a time against a 64-bit, word-addressed memory port. A request carries:

- a byte address and an operand size of 4 or 8 bytes;
- a 3-bit increment code;
- a page-kind field and separate read and write permission bits;
- a locality hint, which the unit takes but does not use.

The unit first classifies the request for faults, using only combinational checks on the request fields. A faulting request goes straight to the response with a fault code and never touches memory. A clean request goes through four steps:

1. The unit reads the addressed word and zero-extends the selected operand.
2. It adds the sign-extended increment to that operand.
3. It writes the truncated sum back to the same word, using byte strobes.
4. It returns the pre-add operand, zero-extended to 64 bits.

A lock output stays high from the read request until the write is accepted, so the memory side can keep other masters out for the whole read-modify-write.

Requests and responses are valid/ready streams. The request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle. The response is offered with `rsp_valid` and held unchanged until `rsp_ready` is seen. No new request is taken until that happens.

The memory request side is also valid/ready: `mem_valid` and its address, write enable, data and strobes stay stable until `mem_ready`. Read data comes back later, on a single-cycle `mem_rvalid` pulse. Within a 64-bit word, byte lanes are little-endian.

Top module: `fadd_unit`

## Requirements
- R1: An 8-byte request on a clean page returns the old word and writes back old + inc modulo 2^64. The increment codes 3'b000..3'b111 mean -16, -8, -4, -1, +1, +4, +8, +16 in that order, sign-extended to 64 bits.
- R2: A 4-byte request uses byte-address bit 2 to pick its half of the word: 0 selects bytes 0..3 (bits 31:0) and 1 selects bytes 4..7 (bits 63:32). The sum is kept modulo 2^32. Only that half's four strobes are set, so the other half of memory is unchanged. The returned value is the old half, zero-extended.
- R3: An 8-byte request with address bits [2:0] not zero, or a 4-byte request with address bits [1:0] not zero, gets fault code 1 (unaligned). The value of `cfg_align_chk` does not change this.
- R4: The page-kind field is coded 2'b00 write-back cacheable, 2'b01 uncached-exportable, 2'b10 poison page and 2'b11 other. A poison page gets fault code 2. Kind 2'b11 gets fault code 3 (unsupported).
- R5: On an uncached-exportable page with `cfg_export_en`=1, the operation is performed and `rsp_exported`=1. With `cfg_export_en`=0, the request gets fault code 3. Write-back pages always give `rsp_exported`=0.
- R6: A request on an accepted page with `req_can_read`=0 or `req_can_write`=0 gets fault code 4 (access rights). The write-permission check applies even though the request has not yet written anything.
- R7: Fault priority is unaligned, then poison page, then unsupported, then access rights. A faulting request issues no memory request and returns `rsp_old`=0 with `rsp_exported`=0. Fault code 0 means success.
- R8: Every memory request is made with `mem_lock` high. The lock rises together with the read request and falls only after the write is accepted. The write goes to the word that was read. `req_ready` is low while the lock is held.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response fields stay unchanged. `rsp_defer` (the deferred-exception flag of the result) is always 0.
- R10: The value of `req_hint` has no effect on the returned value, the fault code or the memory contents.
- R11: After reset, `req_ready`=1, and `rsp_valid`, `mem_valid` and `mem_lock` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_export_en | input | 1 | 1 = uncached-exportable pages are performed and flagged as exported |
| cfg_align_chk | input | 1 | Alignment-check enable; the alignment check ignores it |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (unit idle) |
| req_addr | input | ADDR_W | Byte address |
| req_wide | input | 1 | 1 = 8-byte operand, 0 = 4-byte operand |
| req_inc | input | 3 | Increment code |
| req_page | input | 2 | Page kind |
| req_can_read | input | 1 | Read permission on the page |
| req_can_write | input | 1 | Write permission on the page |
| req_hint | input | 2 | Locality hint (no effect) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_old | output | 64 | Pre-add operand, zero-extended |
| rsp_fault | output | 3 | Fault code (0 = none) |
| rsp_exported | output | 1 | Operation was flagged as exported |
| rsp_defer | output | 1 | Deferred-exception flag of the result, always 0 |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W-3 | 64-bit word address |
| mem_wdata | output | 64 | Write data |
| mem_wstrb | output | 8 | Byte write strobes, bit i for byte i |
| mem_rdata | input | 64 | Read data |
| mem_rvalid | input | 1 | Read data valid, one pulse per read |
| mem_lock | output | 1 | Memory lock held across the read-modify-write |

## Verification
The fault code is registered when the request is taken. A wrong fault classification therefore shows up on `rsp_fault` in the first response, a single cycle after acceptance. It also shows as a memory read where none should occur, or a missing one.

A wrong lane select or wrong increment decoding shows in two places. The value returned for the first operation on a word is wrong. The word read back by the next operation on that word is also wrong, because the bench chains operations on the same word.

A controller that drops the lock early, or that takes a request while busy, shows as a memory request with `mem_lock` low, or as `req_ready` high while the lock is held. Both appear within the same operation, including under memory stalls.

// File: rtl/fadd_pkg.sv
package fadd_pkg;

  typedef enum logic [1:0] {
    PG_WB     = 2'b00,
    PG_UCX    = 2'b01,
    PG_POISON = 2'b10,
    PG_OTHER  = 2'b11
  } page_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_UNALIGNED = 3'd1,
    FLT_POISON    = 3'd2,
    FLT_UNSUP     = 3'd3,
    FLT_ACCESS    = 3'd4
  } fault_e;

  localparam int unsigned WORD_W  = 64;
  localparam int unsigned HALF_W  = WORD_W / 2;
  localparam int unsigned LANES   = WORD_W / 8;

  // Increment codes, ascending: -16, -8, -4, -1, +1, +4, +8, +16
  function automatic logic [WORD_W-1:0] inc_value(input logic [2:0] code);
    logic signed [5:0] v;
    case (code)
      3'd0:    v = -6'sd16;
      3'd1:    v = -6'sd8;
      3'd2:    v = -6'sd4;
      3'd3:    v = -6'sd1;
      3'd4:    v = 6'sd1;
      3'd5:    v = 6'sd4;
      3'd6:    v = 6'sd8;
      default: v = 6'sd16;
    endcase
    return {{(WORD_W-6){v[5]}}, v};
  endfunction

endpackage

// File: rtl/fadd_check.sv
module fadd_check
  import fadd_pkg::*;
(
  input  logic [2:0] addr_lo,
  input  logic       wide,
  input  logic [1:0] page,
  input  logic       can_rd,
  input  logic       can_wr,
  input  logic       export_en,
  output fault_e     fault,
  output logic       exported
);

  logic       misaligned;
  page_kind_e kind;

  assign kind       = page_kind_e'(page);
  assign misaligned = wide ? (|addr_lo) : (|addr_lo[1:0]);

  // Fixed priority: alignment, poison, attribute, permission
  always_comb begin
    exported = 1'b0;
    if (misaligned)
      fault = FLT_UNALIGNED;
    else if (kind == PG_POISON)
      fault = FLT_POISON;
    else if (kind == PG_OTHER || (kind == PG_UCX && !export_en))
      fault = FLT_UNSUP;
    else if (!(can_rd && can_wr))
      fault = FLT_ACCESS;
    else begin
      fault    = FLT_NONE;
      exported = (kind == PG_UCX);
    end
  end

endmodule

// File: rtl/fadd_alu.sv
module fadd_alu
  import fadd_pkg::*;
(
  input  logic [WORD_W-1:0] rd_word,
  input  logic              wide,
  input  logic              off_hi,
  input  logic [2:0]        inc_code,
  output logic [WORD_W-1:0] old_ext,
  output logic [WORD_W-1:0] wdata,
  output logic [LANES-1:0]  wstrb
);

  localparam int unsigned HALVES     = 2;
  localparam int unsigned LANES_HALF = LANES / HALVES;

  logic [HALF_W-1:0] half_sel;
  logic [WORD_W-1:0] sum;

  assign half_sel = off_hi ? rd_word[WORD_W-1:HALF_W] : rd_word[HALF_W-1:0];
  assign old_ext  = wide ? rd_word : {{HALF_W{1'b0}}, half_sel};
  assign sum      = old_ext + inc_value(inc_code);

  // Each half lane: full sum slice when wide, low half of sum replicated otherwise
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign wdata[h*HALF_W +: HALF_W] = wide ? sum[h*HALF_W +: HALF_W] : sum[HALF_W-1:0];
    assign wstrb[h*LANES_HALF +: LANES_HALF] =
      (wide || (off_hi == (h == 1))) ? {LANES_HALF{1'b1}} : {LANES_HALF{1'b0}};
  end

endmodule

// File: rtl/fadd_ctrl.sv
module fadd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic fault_bad,
  input  logic mem_ready,
  input  logic mem_rvalid,
  input  logic rsp_ready,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic mem_valid,
  output logic mem_we,
  output logic mem_lock,
  output logic rsp_valid
);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RWAIT, S_WR, S_RESP} state_e;
  state_e state, state_nx;

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = (state == S_RWAIT) && mem_rvalid;
  assign mem_valid = (state == S_RD) || (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign mem_lock  = (state == S_RD) || (state == S_RWAIT) || (state == S_WR);
  assign rsp_valid = (state == S_RESP);

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:  if (req_valid) state_nx = fault_bad ? S_RESP : S_RD;
      S_RD:    if (mem_ready) state_nx = S_RWAIT;
      S_RWAIT: if (mem_rvalid) state_nx = S_WR;
      S_WR:    if (mem_ready) state_nx = S_RESP;
      S_RESP:  if (rsp_ready) state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

  p_mem_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_lock);
  p_lock_starts_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_lock) |-> (mem_valid && !mem_we));
  p_unlock_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock) |-> $past(mem_valid && mem_we && mem_ready));
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> !req_ready);
  p_fault_skips_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fault_bad) |=> (rsp_valid && !mem_lock));

endmodule

// File: rtl/fadd_unit.sv
module fadd_unit
  import fadd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_export_en,
  input  logic                cfg_align_chk,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_wide,
  input  logic [2:0]          req_inc,
  input  logic [1:0]          req_page,
  input  logic                req_can_read,
  input  logic                req_can_write,
  input  logic [1:0]          req_hint,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [63:0]         rsp_old,
  output logic [2:0]          rsp_fault,
  output logic                rsp_exported,
  output logic                rsp_defer,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic [ADDR_W-4:0]   mem_addr,
  output logic [63:0]         mem_wdata,
  output logic [7:0]          mem_wstrb,
  input  logic [63:0]         mem_rdata,
  input  logic                mem_rvalid,
  output logic                mem_lock
);

  localparam int unsigned WADDR_W = ADDR_W - 3;

  fault_e             fault_now, fault_q;
  logic               exp_now, exp_q;
  logic               accept, capture;
  logic [ADDR_W-1:0]  addr_q;
  logic               wide_q;
  logic [2:0]         inc_q;
  logic [WORD_W-1:0]  rd_q;

  // Hint and alignment-check enable deliberately have no effect
  logic unused_inputs;
  assign unused_inputs = ^{req_hint, cfg_align_chk};

  fadd_check u_check (
    .addr_lo   (req_addr[2:0]),
    .wide      (req_wide),
    .page      (req_page),
    .can_rd    (req_can_read),
    .can_wr    (req_can_write),
    .export_en (cfg_export_en),
    .fault     (fault_now),
    .exported  (exp_now)
  );

  fadd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .fault_bad  (fault_now != FLT_NONE),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .rsp_ready  (rsp_ready),
    .req_ready  (req_ready),
    .accept     (accept),
    .capture    (capture),
    .mem_valid  (mem_valid),
    .mem_we     (mem_we),
    .mem_lock   (mem_lock),
    .rsp_valid  (rsp_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wide_q  <= 1'b0;
      inc_q   <= '0;
      fault_q <= FLT_NONE;
      exp_q   <= 1'b0;
      rd_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wide_q  <= req_wide;
      inc_q   <= req_inc;
      fault_q <= fault_now;
      exp_q   <= exp_now;
      rd_q    <= '0;
    end else if (capture) begin
      rd_q    <= mem_rdata;
    end
  end

  fadd_alu u_alu (
    .rd_word  (rd_q),
    .wide     (wide_q),
    .off_hi   (addr_q[2]),
    .inc_code (inc_q),
    .old_ext  (rsp_old),
    .wdata    (mem_wdata),
    .wstrb    (mem_wstrb)
  );

  assign mem_addr     = addr_q[ADDR_W-1:3];
  assign rsp_fault    = fault_q;
  assign rsp_exported = exp_q;
  assign rsp_defer    = 1'b0;

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_old) &&
                                   $stable(rsp_fault) && $stable(rsp_exported)));
  p_fault_no_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_old == 64'd0 && !rsp_exported));
  p_word_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_addr == addr_q[ADDR_W-1:3]) && $stable(mem_addr));
  p_half_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> ($countones(mem_wstrb) == (wide_q ? 8 : 4)));

endmodule

// File: tb/fadd_unit_tb_top.sv
module fadd_unit_tb_top;

  localparam int ADDR_W = 16;
  localparam int LIMIT  = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_export_en = 1'b0, cfg_align_chk = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_wide = 1'b0;
  logic [2:0] req_inc = '0;
  logic [1:0] req_page = '0;
  logic req_can_read = 1'b1, req_can_write = 1'b1;
  logic [1:0] req_hint = '0;
  logic rsp_valid, rsp_ready = 1'b0;
  logic [63:0] rsp_old;
  logic [2:0] rsp_fault;
  logic rsp_exported, rsp_defer;
  logic mem_valid, mem_ready, mem_we, mem_lock;
  logic [ADDR_W-4:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic [7:0] mem_wstrb;
  logic mem_rvalid;

  fadd_unit #(.ADDR_W(ADDR_W)) dut_i (.*);

  int tests = 0, fails = 0, cyc = 0;
  int rd_cnt = 0, wr_cnt = 0, viol = 0;
  logic stall_en = 1'b0;
  logic [63:0] mem [8];

  assign mem_ready = !(stall_en && cyc[1]);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    if (rst_n) begin
      if (mem_valid && !mem_lock) viol <= viol + 1;
      if (mem_lock && req_ready)  viol <= viol + 1;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          for (int b = 0; b < 8; b++)
            if (mem_wstrb[b]) mem[mem_addr[2:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rdata  <= mem[mem_addr[2:0]];
          mem_rvalid <= 1'b1;
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
    if (cyc == LIMIT) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run hung, cycles %0d expected < %0d", cyc, LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] incv(input logic [2:0] c);
    case (c)
      3'd0: return -64'sd16;
      3'd1: return -64'sd8;
      3'd2: return -64'sd4;
      3'd3: return -64'sd1;
      3'd4: return 64'd1;
      3'd5: return 64'd4;
      3'd6: return 64'd8;
      default: return 64'd16;
    endcase
  endfunction

  logic [63:0] r_old;
  logic [2:0]  r_fault;
  logic        r_exp;
  int          r_rd, r_wr;

  task automatic run_op(input logic [15:0] a, input logic w, input logic [2:0] c,
                        input logic [1:0] pg, input logic cr, input logic cw,
                        input logic [1:0] h);
    int rd0 = rd_cnt, wr0 = wr_cnt;
    @(negedge clk);
    req_addr = a; req_wide = w; req_inc = c; req_page = pg;
    req_can_read = cr; req_can_write = cw; req_hint = h; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r_old = rsp_old; r_fault = rsp_fault; r_exp = rsp_exported;
    check("R9 defer flag", {63'd0, rsp_defer}, 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    r_rd = rd_cnt - rd0; r_wr = wr_cnt - wr0;
  endtask

  task automatic t_reset();
    check("R11 req_ready", {63'd0, req_ready}, 64'd1);
    check("R11 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("R11 mem_valid", {63'd0, mem_valid}, 64'd0);
    check("R11 mem_lock",  {63'd0, mem_lock},  64'd0);
  endtask

  task automatic t_codes_r1();
    logic [63:0] model = 64'h0000_0001_0000_0100;
    mem[1] = model;
    for (int c = 0; c < 8; c++) begin
      run_op(16'h0008, 1'b1, 3'(c), 2'b00, 1'b1, 1'b1, 2'd0);
      check("R1 old value", r_old, model);
      check("R1 fault", {61'd0, r_fault}, 64'd0);
      model = model + incv(3'(c));
      check("R1 memory", mem[1], model);
    end
    mem[3] = 64'd0;
    run_op(16'h0018, 1'b1, 3'd3, 2'b00, 1'b1, 1'b1, 2'd0);
    check("R1 wrap old", r_old, 64'd0);
    check("R1 wrap memory", mem[3], 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_half_r2();
    mem[2] = 64'hAAAA_BBBB_FFFF_FFFF;
    run_op(16'h0010, 1'b0, 3'd4, 2'b00, 1'b1, 1'b1, 2'd0);
    check("R2 low old", r_old, 64'h0000_0000_FFFF_FFFF);
    check("R2 low wrap memory", mem[2], 64'hAAAA_BBBB_0000_0000);
    run_op(16'h0014, 1'b0, 3'd0, 2'b00, 1'b1, 1'b1, 2'd0);
    check("R2 high old", r_old, 64'h0000_0000_AAAA_BBBB);
    check("R2 high memory", mem[2], 64'hAAAA_BBAB_0000_0000);
  endtask

  task automatic t_faults_r3_r4_r6_r7();
    cfg_align_chk = 1'b0;
    run_op(16'h000C, 1'b1, 3'd4, 2'b00, 1'b1, 1'b1, 2'd0);
    check("R3 8-byte unaligned", {61'd0, r_fault}, 64'd1);
    run_op(16'h0011, 1'b0, 3'd4, 2'b00, 1'b1, 1'b1, 2'd0);
    check("R3 4-byte unaligned", {61'd0, r_fault}, 64'd1);
    cfg_align_chk = 1'b1;
    run_op(16'h0010, 1'b1, 3'd4, 2'b10, 1'b1, 1'b1, 2'd0);
    check("R4 poison page", {61'd0, r_fault}, 64'd2);
    run_op(16'h0010, 1'b1, 3'd4, 2'b11, 1'b1, 1'b1, 2'd0);
    check("R4 other page", {61'd0, r_fault}, 64'd3);
    run_op(16'h0010, 1'b1, 3'd4, 2'b00, 1'b0, 1'b1, 2'd0);
    check("R6 no read", {61'd0, r_fault}, 64'd4);
    run_op(16'h0010, 1'b1, 3'd4, 2'b00, 1'b1, 1'b0, 2'd0);
    check("R6 no write", {61'd0, r_fault}, 64'd4);
    check("R7 no memory access", 64'(r_rd + r_wr), 64'd0);
    check("R7 old zero", r_old, 64'd0);
    run_op(16'h0012, 1'b0, 3'd4, 2'b10, 1'b0, 1'b0, 2'd0);
    check("R7 unaligned beats poison", {61'd0, r_fault}, 64'd1);
    run_op(16'h0010, 1'b0, 3'd4, 2'b10, 1'b0, 1'b0, 2'd0);
    check("R7 poison beats rights", {61'd0, r_fault}, 64'd2);
    run_op(16'h0010, 1'b0, 3'd4, 2'b11, 1'b0, 1'b0, 2'd0);
    check("R7 unsupported beats rights", {61'd0, r_fault}, 64'd3);
    check("R7 memory untouched", mem[2], 64'hAAAA_BBAB_0000_0000);
  endtask

  task automatic t_export_r5();
    mem[4] = 64'd100;
    cfg_export_en = 1'b1;
    run_op(16'h0020, 1'b1, 3'd6, 2'b01, 1'b1, 1'b1, 2'd0);
    check("R5 exported flag", {63'd0, r_exp}, 64'd1);
    check("R5 exported old", r_old, 64'd100);
    check("R5 exported memory", mem[4], 64'd108);
    cfg_export_en = 1'b0;
    run_op(16'h0020, 1'b1, 3'd6, 2'b01, 1'b1, 1'b1, 2'd0);
    check("R5 no export fault", {61'd0, r_fault}, 64'd3);
    check("R5 no export access", 64'(r_rd + r_wr), 64'd0);
    run_op(16'h0020, 1'b1, 3'd6, 2'b00, 1'b1, 1'b1, 2'd0);
    check("R5 write-back not exported", {63'd0, r_exp}, 64'd0);
  endtask

  task automatic t_hint_r10();
    mem[5] = 64'h50;
    run_op(16'h0028, 1'b1, 3'd7, 2'b00, 1'b1, 1'b1, 2'd3);
    check("R10 hint3 old", r_old, 64'h50);
    run_op(16'h0028, 1'b1, 3'd7, 2'b00, 1'b1, 1'b1, 2'd1);
    check("R10 hint1 old", r_old, 64'h60);
    check("R10 memory", mem[5], 64'h70);
  endtask

  task automatic t_backpressure_r9();
    logic [63:0] first;
    mem[6] = 64'h1234;
    @(negedge clk);
    req_addr = 16'h0030; req_wide = 1'b1; req_inc = 3'd5; req_page = 2'b00;
    req_can_read = 1'b1; req_can_write = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    first = rsp_old;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 valid held", {63'd0, rsp_valid}, 64'd1);
      check("R9 data held", rsp_old, first);
      check("R9 busy no accept", {63'd0, req_ready}, 64'd0);
    end
    check("R9 old value", first, 64'h1234);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R9 idle after handshake", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic t_stall_r8();
    mem[7] = 64'hFFFF_FFFF_0000_0008;
    stall_en = 1'b1;
    run_op(16'h003C, 1'b0, 3'd4, 2'b00, 1'b1, 1'b1, 2'd0);
    stall_en = 1'b0;
    check("R8 stalled old", r_old, 64'hFFFF_FFFF);
    check("R8 stalled memory", mem[7], 64'h0000_0000_0000_0008);
    check("R8 one read", 64'(r_rd), 64'd1);
    check("R8 one write", 64'(r_wr), 64'd1);
    check("R8 lock violations", 64'(viol), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_codes_r1();
    t_half_r2();
    t_faults_r3_r4_r6_r7();
    t_export_r5();
    t_hint_r10();
    t_backpressure_r9();
    t_stall_r8();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule